// File: doc/BRIEF.md
# Alternating-Channel Serial ADC Reader

This block is the host-side controller for a two-channel, 10-bit successive-approximation converter attached through a three-wire serial link (chip-select, serial clock, serial data out of the converter). The converter takes no channel command. After power-up it converts channel 0, and every later chip-select low period converts the other channel. The controller therefore keeps a mirror of the channel the converter will take next. When a request asks for that channel, one frame is enough. When it asks for the other one, the controller first sends a short chip-select pulse that carries no serial clock. That pulse moves the converter on by one channel before the real frame.

Each frame holds chip-select low for 16 serial clock periods. The serial clock idles low and has a 50% duty cycle, and each phase lasts a parameterised number of system clocks. Input bits are sampled on the rising serial clock edge. Bit positions 0 to 4 are discarded. Position 5 is the channel identification bit, and positions 6 to 15 are the code from its most significant bit down to its least significant bit. The five leading positions give the converter more than its two acquisition clocks before any data. The result comes out with a one-cycle valid strobe, the received channel tag and an error flag. The flag is set when the received tag differs from the mirror's expectation. In that case the mirror is resynchronised to the received tag.

The controller is a five-state machine. IDLE waits for a start strobe (IDLE to HOLD). HOLD keeps chip-select high until the minimum high time has elapsed. It then moves to DUMMY if a channel skip is pending, and to FRAME otherwise. DUMMY holds chip-select low for a fixed dwell with no serial clock and returns to HOLD. FRAME runs the 16 serial clock periods and moves to DONE after the last falling edge. DONE raises chip-select, presents the result for one cycle and returns to IDLE.

Top module: `adc_alt_reader`

## Requirements
- R1: While reset is active and after its release with no request, `adc_cs_n` is 1, `adc_sclk` is 0, `busy` is 0 and `res_valid` is 0.
- R2: Every conversion frame holds `adc_cs_n` low for exactly 16 rising edges of `adc_sclk`. `adc_sclk` is 0 whenever `adc_cs_n` is 1 and when chip-select falls, and each serial clock phase lasts HALF_DIV system clocks.
- R3: The next-channel mirror is 0 after reset and toggles on every falling edge of `adc_cs_n`. A request for the mirrored channel produces exactly one chip-select low period.
- R4: A request for the channel other than the mirrored one produces two chip-select low periods. The first lasts DUMMY_LEN system clocks and contains no serial clock edge. The second is the data frame.
- R5: The frame is sampled on rising serial clock edges, counting positions from 0. Position 5 is returned on `res_chan`, and positions 6 to 15 are returned on `res_code` bits 9 down to 0.
- R6: `busy` is 1 from the cycle after an accepted start until the cycle `res_valid` is high, inclusive. `res_valid` is high for exactly one cycle with `adc_cs_n` high, and `busy` is 0 in the cycle after it.
- R7: `res_err` is 1 with the result exactly when the received channel bit differs from the channel the mirror predicted. The mirror then becomes the inverse of the received bit, so a following request for that channel needs no skip pulse.
- R8: `adc_cs_n` stays high for at least CS_GAP system clocks before every falling edge, including the first one after reset.
- R9: A start strobe that arrives while `busy` is 1 is ignored. It changes neither the current result nor the chip-select activity that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start strobe, taken only while idle |
| req_chan | input | 1 | Channel wanted by the request |
| busy | output | 1 | Request in progress |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_sdo | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | CODE_W | Converted code |
| res_chan | output | 1 | Channel tag received in the frame |
| res_err | output | 1 | Received tag differed from the prediction |

## Verification
The bound checker watches the serial framing on every cycle. It confirms that the serial clock only toggles under an active chip-select and that every low period carries either zero or sixteen rising edges. It also checks the minimum chip-select high time before each fall, and that the result strobe is a single cycle while busy and chip-select are high. Three behaviours depend on a model of the converter's hidden channel state, so only the bench scenarios can show them: whether a skip pulse was needed, whether the returned code and tag belong to the channel actually converted, and whether a deliberately slipped converter raises the error once and then resynchronises. The bench also shows that strobes during a busy period are ignored.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_DUMMY,
        ST_FRAME,
        ST_DONE
    } rd_state_e;

endpackage

// File: rtl/adc_rd_sclk_div.sv
// Serial clock generator: idles low, each phase HALF_DIV system clocks.
module adc_rd_sclk_div #(
    parameter int HALF_DIV = 58
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] PH_LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] ph_cnt;
    logic          ph_end;

    assign ph_end = run && (ph_cnt == PH_LAST);
    assign rise   = ph_end && !sclk;
    assign fall   = ph_end && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt <= '0;
            sclk   <= 1'b0;
        end else if (!run) begin
            ph_cnt <= '0;
            sclk   <= 1'b0;
        end else if (ph_end) begin
            ph_cnt <= '0;
            sclk   <= ~sclk;
        end else begin
            ph_cnt <= ph_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rd_shifter.sv
// Frame receiver: shifts one bit per rising serial edge and splits the frame.
module adc_rd_shifter #(
    parameter int FRAME_BITS = 16,
    parameter int CODE_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi,
    output logic              frame_done,
    output logic [CODE_W-1:0] rx_code,
    output logic              rx_chan
);
    localparam int BW = $clog2(FRAME_BITS + 1);
    localparam logic [BW-1:0] ALL_BITS = BW'(FRAME_BITS);
    // channel bit sits just ahead of the code, so after the last shift
    // it lands directly above the code field
    localparam int TAG_IDX = CODE_W;

    logic [FRAME_BITS-1:0] sr;
    logic [BW-1:0]         n_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr     <= '0;
            n_bits <= '0;
        end else if (clear) begin
            n_bits <= '0;
        end else if (rise) begin
            sr     <= {sr[FRAME_BITS-2:0], sdi};
            n_bits <= n_bits + 1'b1;
        end
    end

    assign frame_done = fall && (n_bits == ALL_BITS);
    assign rx_code    = sr[CODE_W-1:0];
    assign rx_chan    = sr[TAG_IDX];
endmodule

// File: rtl/adc_rd_cycle_cnt.sv
// Saturating dwell counter: reached is high in the LIMIT-th cycle after clear drops.
module adc_rd_cycle_cnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic reached
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign reached = (cnt == TOP);
endmodule

// File: rtl/adc_alt_reader.sv
module adc_alt_reader
    import adc_rd_pkg::*;
#(
    parameter int HALF_DIV   = 58,
    parameter int CS_GAP     = 16,
    parameter int DUMMY_LEN  = 8,
    parameter int FRAME_BITS = 16,
    parameter int CODE_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_chan,
    output logic              busy,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    input  logic              adc_sdo,
    output logic              res_valid,
    output logic [CODE_W-1:0] res_code,
    output logic              res_chan,
    output logic              res_err
);
    rd_state_e state_q, state_d;

    logic              cs_low;
    logic              sclk_run;
    logic              sclk_rise, sclk_fall;
    logic              gap_done, dwell_done;
    logic              frame_done;
    logic [CODE_W-1:0] rx_code;
    logic              rx_chan;
    logic              mirror_q;
    logic              conv_q;
    logic              skip_q;

    adc_rd_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sclk_run),
        .sclk  (adc_sclk),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    adc_rd_shifter #(.FRAME_BITS(FRAME_BITS), .CODE_W(CODE_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!sclk_run),
        .rise       (sclk_rise),
        .fall       (sclk_fall),
        .sdi        (adc_sdo),
        .frame_done (frame_done),
        .rx_code    (rx_code),
        .rx_chan    (rx_chan)
    );

    adc_rd_cycle_cnt #(.LIMIT(CS_GAP)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cs_low),
        .reached (gap_done)
    );

    adc_rd_cycle_cnt #(.LIMIT(DUMMY_LEN)) u_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q != ST_DUMMY),
        .reached (dwell_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)  state_d = ST_HOLD;
            ST_HOLD:  if (gap_done)   state_d = skip_q ? ST_DUMMY : ST_FRAME;
            ST_DUMMY: if (dwell_done) state_d = ST_HOLD;
            ST_FRAME: if (frame_done) state_d = ST_DONE;
            ST_DONE:                  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cs_low    = (state_q == ST_DUMMY) || (state_q == ST_FRAME);
        adc_cs_n  = !cs_low;
        sclk_run  = (state_q == ST_FRAME);
        busy      = (state_q != ST_IDLE);
        res_valid = (state_q == ST_DONE);
    end

    // channel mirror and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mirror_q <= 1'b0;
            conv_q   <= 1'b0;
            skip_q   <= 1'b0;
            res_code <= '0;
            res_chan <= 1'b0;
            res_err  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                skip_q <= (req_chan != mirror_q);
            end
            if (state_q == ST_HOLD && gap_done) begin
                // chip-select falls next cycle: converter advances
                mirror_q <= ~mirror_q;
                if (skip_q) begin
                    skip_q <= 1'b0;
                end else begin
                    conv_q <= mirror_q;
                end
            end
            if (state_q == ST_FRAME && frame_done) begin
                res_code <= rx_code;
                res_chan <= rx_chan;
                res_err  <= (rx_chan != conv_q);
                mirror_q <= ~rx_chan;
            end
        end
    end
endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker #(
    parameter int CS_GAP     = 16,
    parameter int FRAME_BITS = 16
) (
    input logic clk,
    input logic rst_n,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic busy,
    input logic res_valid
);
    int unsigned hi_cnt;
    int unsigned edge_cnt;
    logic        sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt   <= 0;
            edge_cnt <= 0;
            sclk_q   <= 1'b0;
        end else begin
            sclk_q <= adc_sclk;
            if (adc_cs_n) begin
                if (hi_cnt < 32'hFFFF) hi_cnt <= hi_cnt + 1;
                edge_cnt <= 0;
            end else begin
                hi_cnt <= 0;
                if (adc_sclk && !sclk_q) edge_cnt <= edge_cnt + 1;
            end
        end
    end

    // R1: idle outputs while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (adc_cs_n && !adc_sclk && !busy && !res_valid)
                else $error("R1 outputs not idle in reset");
        end
    end

    a_r2_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sclk |-> !adc_cs_n);

    a_r2_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |-> (edge_cnt == 0 || edge_cnt == FRAME_BITS));

    a_r8_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> (hi_cnt >= CS_GAP));

    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r6_valid_context: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (busy && adc_cs_n));

    a_r6_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !busy);
endmodule

bind adc_alt_reader adc_rd_checker #(
    .CS_GAP     (CS_GAP),
    .FRAME_BITS (FRAME_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adc_cs_n  (adc_cs_n),
    .adc_sclk  (adc_sclk),
    .busy      (busy),
    .res_valid (res_valid)
);

// File: tb/tb_adc_alt_reader.sv
module tb_adc_alt_reader;
    localparam int HD = 3;
    localparam int GAP = 5;
    localparam int DW = 3;
    localparam int FB = 16;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_chan = 1'b0;
    logic          adc_sdo = 1'b0;
    logic          busy, adc_cs_n, adc_sclk, res_valid, res_chan, res_err;
    logic [CW-1:0] res_code;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    adc_alt_reader #(
        .HALF_DIV(HD), .CS_GAP(GAP), .DUMMY_LEN(DW), .FRAME_BITS(FB), .CODE_W(CW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .busy(busy), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdo(adc_sdo),
        .res_valid(res_valid), .res_code(res_code), .res_chan(res_chan), .res_err(res_err)
    );

    // converter model: hidden channel state advanced by chip-select falls
    logic          m_next = 1'b0;
    logic          m_cur = 1'b0;
    int            m_bit = 0;
    logic [CW-1:0] m_code [2];

    function automatic logic frame_bit(int k);
        if (k < 5) return 1'b0;
        if (k == 5) return m_cur;
        if (k < FB) return m_code[m_cur][FB-1-k];
        return 1'b0;
    endfunction

    always @(negedge adc_cs_n) begin
        m_cur  = m_next;
        m_next = ~m_next;
        m_bit  = 0;
        adc_sdo = frame_bit(0);
    end

    always @(negedge adc_sclk) begin
        if (!adc_cs_n) begin
            m_bit++;
            adc_sdo = frame_bit(m_bit);
        end
    end

    // line monitor
    bit p_cs = 1'b1, p_sclk = 1'b0;
    int hi_run = 0, ph_len = 0, rises = 0, falls = 0;
    int lp_last = 0, lp_prev = 0, gap_viol = 0, ph_viol = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_cs = 1'b1; p_sclk = 1'b0; hi_run = 0; rises = 0;
        end else begin
            if (adc_cs_n) begin
                if (!p_cs) begin lp_prev = lp_last; lp_last = rises; end
                if (adc_sclk) ph_viol++;
                hi_run++;
            end else if (p_cs) begin
                falls++;
                if (hi_run < GAP) gap_viol++;
                if (adc_sclk) ph_viol++;
                hi_run = 0; rises = 0; ph_len = 1;
            end else if (adc_sclk != p_sclk) begin
                if (ph_len != HD) ph_viol++;
                ph_len = 1;
                if (adc_sclk) rises++;
            end else begin
                ph_len++;
            end
            p_cs = adc_cs_n; p_sclk = adc_sclk;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    logic b_mirror = 1'b0;

    task automatic do_read(logic ch, bit poke, bit slip);
        logic exp_rx;
        bit   skip;
        int   f0;
        int   wd;
        if (slip) m_next = ~m_next;
        skip   = (ch != b_mirror);
        exp_rx = ch ^ slip;
        f0     = falls;
        @(negedge clk);
        req_valid = 1'b1; req_chan = ch;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R6", "busy after start", int'(busy), 1);
        if (poke) begin
            req_valid = 1'b1; req_chan = ~ch;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wd = 0;
        while (!res_valid && wd < 5000) begin
            @(negedge clk);
            wd++;
        end
        if (!res_valid) begin
            chk(1'b0, "R6", "result timeout", 0, 1);
            return;
        end
        chk(res_code == m_code[exp_rx], "R5", "code", int'(res_code), int'(m_code[exp_rx]));
        chk(res_chan == exp_rx, "R5", "channel tag", int'(res_chan), int'(exp_rx));
        chk(res_err == slip, "R7", "error flag", int'(res_err), int'(slip));
        chk(busy == 1'b1, "R6", "busy with valid", int'(busy), 1);
        @(negedge clk);
        chk(res_valid == 1'b0, "R6", "valid width", int'(res_valid), 0);
        chk(busy == 1'b0, "R6", "busy after valid", int'(busy), 0);
        if (skip) begin
            chk(falls - f0 == 2, "R4", "cs falls with skip", falls - f0, 2);
            chk(lp_prev == 0, "R4", "sclk rises in skip pulse", lp_prev, 0);
        end else begin
            chk(falls - f0 == 1, "R3", "cs falls without skip", falls - f0, 1);
        end
        chk(lp_last == FB, "R2", "sclk rises in frame", lp_last, FB);
        b_mirror = ~exp_rx;
        if (poke) begin
            f0 = falls;
            repeat (GAP + 40) @(negedge clk);
            chk(falls == f0, "R9", "activity after ignored start", falls - f0, 0);
            chk(busy == 1'b0, "R9", "busy after ignored start", int'(busy), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        chk(adc_cs_n == 1'b1, "R1", "cs in reset", int'(adc_cs_n), 1);
        chk(adc_sclk == 1'b0, "R1", "sclk in reset", int'(adc_sclk), 0);
        chk(busy == 1'b0 && res_valid == 1'b0, "R1", "busy/valid in reset",
            int'(busy) + int'(res_valid), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(adc_cs_n == 1'b1 && busy == 1'b0, "R1", "idle after reset",
            int'(adc_cs_n) * 2 + int'(busy), 2);

        // directed corners
        m_code[0] = 10'h3FF; m_code[1] = 10'h000;
        do_read(1'b0, 1'b0, 1'b0);          // R3 first channel without skip
        m_code[0] = 10'h155; m_code[1] = 10'h2AA;
        do_read(1'b1, 1'b0, 1'b0);          // R3 alternation
        do_read(1'b1, 1'b1, 1'b0);          // R4 repeat channel, R9 poke
        m_code[0] = 10'h001; m_code[1] = 10'h200;
        do_read(1'b0, 1'b0, 1'b1);          // R7 converter slipped
        do_read(1'b0, 1'b0, 1'b0);          // R7 resynchronised: no skip

        for (int i = 0; i < 24; i++) begin
            m_code[0] = CW'($urandom);
            m_code[1] = CW'($urandom);
            do_read(1'($urandom), ($urandom % 3) == 0, ($urandom % 7) == 0);
        end

        chk(gap_viol == 0, "R8", "short chip-select high", gap_viol, 0);
        chk(ph_viol == 0, "R2", "serial clock phase faults", ph_viol, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule